// File: doc/BRIEF.md
# Time-Base Bit-Tap Interval Timer

This block raises two periodic interrupt requests, a fixed-interval one and a watchdog one, from a free-running 64-bit time-base counter. Each channel taps a single time-base bit picked by its period fields in a control register. Whenever the tapped bit goes from 0 to 1, the channel sets a sticky status flag. The channel's interrupt line is high for as long as that flag and the channel's enable bit are both set.

Software sets the period fields and the enables by writing the control register through a one-cycle write port. It acknowledges an event by writing a 1 to the flag's position in the status register. The time base advances once per clock while a tick-enable input is high. A parameter picks how the tap is chosen. In extended mode, a 2-bit period field and a 4-bit extension field together give the bit index. In compact mode, the 2-bit field alone picks one of four positions set by parameters.

Top module: `tbtap_timer`

## Requirements
- R1: After reset, the control register reads 0, the status register reads 0, the time base reads 0 and both interrupt lines are low.
- R2: The time base goes up by exactly one on each clock where `tick_en` is high, and it holds its value on each clock where `tick_en` is low.
- R3: A write with `wr_addr`=0 stores all 32 bits of `wr_data` in the control register. The field positions are: watchdog period at bits 31:30, watchdog enable at bit 27, fixed-interval period at bits 25:24, fixed-interval enable at bit 23, watchdog extension at bits 20:17 and fixed-interval extension at bits 16:13.
- R4: In extended mode (the default), each channel taps the time-base bit 63 − (period | extension << 2).
- R5: In compact mode, the extension fields have no effect, and period select p taps bit `NX_TAP_LO + NX_TAP_STEP*p`.
- R6: A channel's flag is set only when its tapped bit goes from 0 to 1. A 1-to-0 change of that bit leaves the flag unchanged. The fixed-interval flag reads at status bit 26 and the watchdog flag at status bit 30. All other status bits read 0.
- R7: A write with `wr_addr`=1 clears each flag whose bit is 1 in `wr_data` and leaves each flag whose bit is 0 unchanged.
- R8: `fit_irq` equals fixed-interval flag AND control bit 23, and `wdt_irq` equals watchdog flag AND control bit 27. Both follow a control or status write in the next cycle.
- R9: When a control write moves a tap onto a bit that is already 1, no event results.
- R10: If an event and a clearing write hit the same flag in the same cycle, the flag ends up set. An event that arrives while the flag is already set leaves the flag set and is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Advance the time base this cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = control, 1 = status (write-one-to-clear) |
| wr_data | input | 32 | Write data |
| ctrl_q | output | 32 | Current control register |
| stat_q | output | 32 | Current status register |
| tb_val | output | 64 | Current time-base value |
| fit_irq | output | 1 | Fixed-interval interrupt request |
| wdt_irq | output | 1 | Watchdog interrupt request |

## Verification
Two things can land on the same flag in one cycle: the set from a tapped-bit rising edge, and the clear from a status write. The bench stops the time base with the fixed-interval tap on bit 0 and an even count. It then lets exactly one tick through, so bit 0 rises, and issues the clearing write on the next edge. The flag must read 1 afterwards, and a later write on its own must clear it. A second conflict comes from a control write that moves the tap onto a bit that is already high. That case is judged by confirming the flag stays at 0.

// File: rtl/tbtap_pkg.sv
package tbtap_pkg;

    localparam int CTRL_WP_LSB   = 30;
    localparam int CTRL_WIE      = 27;
    localparam int CTRL_FP_LSB   = 24;
    localparam int CTRL_FIE      = 23;
    localparam int CTRL_WEXT_LSB = 17;
    localparam int CTRL_FEXT_LSB = 13;
    localparam int STAT_FIT      = 26;
    localparam int STAT_WDT      = 30;

    typedef enum logic {
        ADDR_CTRL = 1'b0,
        ADDR_STAT = 1'b1
    } reg_addr_e;

    typedef struct packed {
        logic [31:0] ctrl;
        logic        fit_flag;
        logic        wdt_flag;
    } regs_t;

    typedef struct packed {
        logic prev;
        logic hold;
    } edge_st_t;

endpackage

// File: rtl/tbtap_timebase.sv
module tbtap_timebase #(
    parameter int TB_W = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_en,
    output logic [TB_W-1:0] count
);

    logic [TB_W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (tick_en) count_d = count_q + TB_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign count = count_q;

endmodule

// File: rtl/tbtap_tapsel.sv
module tbtap_tapsel #(
    parameter int TB_W        = 64,
    parameter int IDX_W       = 6,
    parameter bit EXT_MODE    = 1'b1,
    parameter int NX_TAP_LO   = 20,
    parameter int NX_TAP_STEP = 4
) (
    input  logic [1:0]       per,
    input  logic [3:0]       ext,
    output logic [IDX_W-1:0] idx
);

    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(TB_W - 1);

    generate
        if (EXT_MODE) begin : g_ext
            always_comb idx = TOP_IDX - IDX_W'({ext, per});
        end else begin : g_tbl
            logic [IDX_W-1:0] pos [4];
            for (genvar g = 0; g < 4; g++) begin : g_pos
                assign pos[g] = IDX_W'(NX_TAP_LO + NX_TAP_STEP * g);
            end
            logic unused_ext;
            assign unused_ext = ^ext;
            always_comb idx = pos[per];
        end
    endgenerate

endmodule

// File: rtl/tbtap_edge.sv
module tbtap_edge
    import tbtap_pkg::*;
#(
    parameter int TB_W  = 64,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TB_W-1:0]  tb,
    input  logic [IDX_W-1:0] idx,
    input  logic             resync,
    output logic             evt
);

    edge_st_t st_d, st_q;
    logic     tap;

    always_comb begin
        tap       = tb[idx];
        evt       = tap && !st_q.prev && !st_q.hold;
        st_d.prev = tap;
        st_d.hold = resync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/tbtap_timer.sv
module tbtap_timer
    import tbtap_pkg::*;
#(
    parameter int TB_W        = 64,
    parameter bit EXT_MODE    = 1'b1,
    parameter int NX_TAP_LO   = 20,
    parameter int NX_TAP_STEP = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_en,
    input  logic            wr_en,
    input  logic            wr_addr,
    input  logic [31:0]     wr_data,
    output logic [31:0]     ctrl_q,
    output logic [31:0]     stat_q,
    output logic [TB_W-1:0] tb_val,
    output logic            fit_irq,
    output logic            wdt_irq
);

    localparam int IDX_W = $clog2(TB_W);

    regs_t            r_d, r_q;
    logic             fit_evt, wdt_evt;
    logic             ctrl_wr, stat_wr;
    logic [IDX_W-1:0] fit_idx, wdt_idx;

    assign ctrl_wr = wr_en && (reg_addr_e'(wr_addr) == ADDR_CTRL);
    assign stat_wr = wr_en && (reg_addr_e'(wr_addr) == ADDR_STAT);

    tbtap_timebase #(.TB_W(TB_W)) u_tb (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .count   (tb_val)
    );

    tbtap_tapsel #(
        .TB_W(TB_W), .IDX_W(IDX_W), .EXT_MODE(EXT_MODE),
        .NX_TAP_LO(NX_TAP_LO), .NX_TAP_STEP(NX_TAP_STEP)
    ) u_fit_sel (
        .per (r_q.ctrl[CTRL_FP_LSB +: 2]),
        .ext (r_q.ctrl[CTRL_FEXT_LSB +: 4]),
        .idx (fit_idx)
    );

    tbtap_tapsel #(
        .TB_W(TB_W), .IDX_W(IDX_W), .EXT_MODE(EXT_MODE),
        .NX_TAP_LO(NX_TAP_LO), .NX_TAP_STEP(NX_TAP_STEP)
    ) u_wdt_sel (
        .per (r_q.ctrl[CTRL_WP_LSB +: 2]),
        .ext (r_q.ctrl[CTRL_WEXT_LSB +: 4]),
        .idx (wdt_idx)
    );

    tbtap_edge #(.TB_W(TB_W), .IDX_W(IDX_W)) u_fit_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .tb     (tb_val),
        .idx    (fit_idx),
        .resync (ctrl_wr),
        .evt    (fit_evt)
    );

    tbtap_edge #(.TB_W(TB_W), .IDX_W(IDX_W)) u_wdt_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .tb     (tb_val),
        .idx    (wdt_idx),
        .resync (ctrl_wr),
        .evt    (wdt_evt)
    );

    always_comb begin
        r_d = r_q;
        if (ctrl_wr) r_d.ctrl = wr_data;
        if (stat_wr) begin
            if (wr_data[STAT_FIT]) r_d.fit_flag = 1'b0;
            if (wr_data[STAT_WDT]) r_d.wdt_flag = 1'b0;
        end
        // a fresh event outranks an acknowledge in the same cycle
        if (fit_evt) r_d.fit_flag = 1'b1;
        if (wdt_evt) r_d.wdt_flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        ctrl_q           = r_q.ctrl;
        stat_q           = '0;
        stat_q[STAT_FIT] = r_q.fit_flag;
        stat_q[STAT_WDT] = r_q.wdt_flag;
        fit_irq          = r_q.fit_flag && r_q.ctrl[CTRL_FIE];
        wdt_irq          = r_q.wdt_flag && r_q.ctrl[CTRL_WIE];
    end

endmodule

// File: rtl/tbtap_timer_chk.sv
module tbtap_timer_chk #(
    parameter int TB_W = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            tick_en,
    input logic            wr_en,
    input logic            wr_addr,
    input logic            wd_fit,
    input logic            wd_wdt,
    input logic            fit_flag,
    input logic            wdt_flag,
    input logic            fie,
    input logic            wie,
    input logic [TB_W-1:0] tb_val,
    input logic            fit_irq,
    input logic            wdt_irq,
    input logic            fit_evt,
    input logic            wdt_evt
);

    a_r2_tb_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(tick_en)) |-> (tb_val == $past(tb_val) + TB_W'(1)));

    a_r2_tb_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(tick_en)) |-> $stable(tb_val));

    a_r7_fit_clear_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fit_flag) |-> $past(wr_en && wr_addr && wd_fit));

    a_r7_wdt_clear_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wdt_flag) |-> $past(wr_en && wr_addr && wd_wdt));

    a_r10_fit_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        fit_evt |=> fit_flag);

    a_r10_wdt_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_evt |=> wdt_flag);

    a_r9_no_evt_after_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
        (fit_evt || wdt_evt) |-> !$past(rst_n && wr_en && !wr_addr));

    a_r8_fit_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fit_irq) |-> ($rose(fit_flag) || $rose(fie)));

    a_r8_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(fit_irq) || $fell(wdt_irq)) |-> $past(wr_en));

    a_r8_wdt_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdt_irq) |-> ($rose(wdt_flag) || $rose(wie)));

endmodule

bind tbtap_timer tbtap_timer_chk #(.TB_W(TB_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wd_fit   (wr_data[tbtap_pkg::STAT_FIT]),
    .wd_wdt   (wr_data[tbtap_pkg::STAT_WDT]),
    .fit_flag (stat_q[tbtap_pkg::STAT_FIT]),
    .wdt_flag (stat_q[tbtap_pkg::STAT_WDT]),
    .fie      (ctrl_q[tbtap_pkg::CTRL_FIE]),
    .wie      (ctrl_q[tbtap_pkg::CTRL_WIE]),
    .tb_val   (tb_val),
    .fit_irq  (fit_irq),
    .wdt_irq  (wdt_irq),
    .fit_evt  (fit_evt),
    .wdt_evt  (wdt_evt)
);

// File: tb/tbtap_timer_test.sv
module tbtap_timer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_addr = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] ctrl_q, stat_q, ctrl_nx, stat_nx;
    logic [63:0] tb_val, tb_nx;
    logic        fit_irq, wdt_irq, fit_irq_nx, wdt_irq_nx;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    tbtap_timer uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .ctrl_q(ctrl_q),
        .stat_q(stat_q), .tb_val(tb_val), .fit_irq(fit_irq), .wdt_irq(wdt_irq)
    );

    tbtap_timer #(.EXT_MODE(1'b0), .NX_TAP_LO(0), .NX_TAP_STEP(1)) uut_nx (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .ctrl_q(ctrl_nx),
        .stat_q(stat_nx), .tb_val(tb_nx), .fit_irq(fit_irq_nx), .wdt_irq(wdt_irq_nx)
    );

    typedef struct packed {
        logic [31:0] ctrl;
        logic [15:0] n;
        logic        fit;
        logic        wdt;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0000, 16'd40,  1'b0, 1'b0},
        '{32'h0381_E000, 16'd4,   1'b1, 1'b0},
        '{32'h881E_0000, 16'd5,   1'b0, 1'b1},
        '{32'h401D_E000, 16'd130, 1'b1, 1'b1},
        '{32'h4B9F_4000, 16'd10,  1'b0, 1'b1}
    };

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick(input int n);
        if (n > 0) begin
            @(negedge clk) tick_en = 1'b1;
            repeat (n) @(posedge clk);
            @(negedge clk) tick_en = 1'b0;
        end
    endtask

    task automatic wr(input logic a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
        end
    end

    initial begin
        logic [63:0] t0;
        logic        efit, ewdt;
        idle(4);
        rst_n = 1'b1;
        idle(2);
        // R1 reset state
        check(ctrl_q == 0, "R1 ctrl", ctrl_q, 0);
        check(stat_q == 0, "R1 stat", stat_q, 0);
        check(tb_val == 0, "R1 tb", tb_val, 0);
        check({fit_irq, wdt_irq} == 2'b00, "R1 irq", {fit_irq, wdt_irq}, 0);

        // R2 counting and holding
        t0 = tb_val;
        tick(37);
        check(tb_val == t0 + 37, "R2 count", tb_val, t0 + 37);
        idle(5);
        check(tb_val == t0 + 37, "R2 hold", tb_val, t0 + 37);

        // R3 control readback
        wr(1'b0, 32'hFFFF_FFFF);
        check(ctrl_q == 32'hFFFF_FFFF, "R3 ctrl all ones", ctrl_q, 32'hFFFF_FFFF);
        wr(1'b0, 32'h1234_5678);
        check(ctrl_q == 32'h1234_5678, "R3 ctrl pattern", ctrl_q, 32'h1234_5678);

        // R4 tap positions, table walk
        for (int i = 0; i < NV; i++) begin
            wr(1'b0, VECS[i].ctrl);
            idle(2);
            wr(1'b1, 32'hFFFF_FFFF);
            tick(int'(VECS[i].n));
            idle(2);
            efit = VECS[i].fit;
            ewdt = VECS[i].wdt;
            check(stat_q[26] == efit, "R4 fit flag", stat_q[26], efit);
            check(stat_q[30] == ewdt, "R4 wdt flag", stat_q[30], ewdt);
            check(fit_irq == (efit & VECS[i].ctrl[23]), "R8 fit irq", fit_irq,
                  efit & VECS[i].ctrl[23]);
            check(wdt_irq == (ewdt & VECS[i].ctrl[27]), "R8 wdt irq", wdt_irq,
                  ewdt & VECS[i].ctrl[27]);
        end

        // R6 rising edge only (fixed-interval tap on bit 1)
        wr(1'b0, 32'h0281_E000);
        tick(int'((4 + 3 - tb_val[1:0]) % 4));
        idle(2);
        wr(1'b1, 32'hFFFF_FFFF);
        check(stat_q[26] == 1'b0, "R6 cleared", stat_q[26], 0);
        tick(1);
        idle(2);
        check(stat_q[26] == 1'b0, "R6 falling ignored", stat_q[26], 0);
        tick(2);
        idle(2);
        check(stat_q[26] == 1'b1, "R6 rising sets", stat_q[26], 1);
        check((stat_q & ~32'h4400_0000) == 0, "R6 other bits", stat_q, 32'h0400_0000);

        // R9 moving the tap onto a high bit (tb low bits now 2'b10)
        wr(1'b0, 32'h0381_E000);
        idle(2);
        wr(1'b1, 32'hFFFF_FFFF);
        wr(1'b0, 32'h0281_E000);
        idle(2);
        check(stat_q[26] == 1'b0, "R9 no spurious event", stat_q[26], 0);

        // R10 event and clear in the same cycle (tap on bit 0)
        wr(1'b0, 32'h0381_E000);
        if (tb_val[0]) tick(1);
        idle(2);
        wr(1'b1, 32'hFFFF_FFFF);
        check(stat_q[26] == 1'b0, "R10 start clear", stat_q[26], 0);
        @(negedge clk) tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0; wr_en = 1'b1; wr_addr = 1'b1; wr_data = 32'h0400_0000;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
        check(stat_q[26] == 1'b1, "R10 set wins", stat_q[26], 1);
        wr(1'b1, 32'h0400_0000);
        check(stat_q[26] == 1'b0, "R10 later clear", stat_q[26], 0);

        // R7 selective clear
        wr(1'b0, 32'h8B9F_E000);
        tick(8);
        idle(2);
        check(stat_q[30:26] == 5'b10001, "R7 both set", stat_q[30:26], 5'b10001);
        wr(1'b1, 32'h4000_0000);
        check(stat_q[26] == 1'b1, "R7 fit kept", stat_q[26], 1);
        check(stat_q[30] == 1'b0, "R7 wdt cleared", stat_q[30], 0);
        wr(1'b1, 32'h0000_0000);
        check(stat_q[26] == 1'b1, "R7 zero write", stat_q[26], 1);

        // R8 enable gating on a set flag
        wr(1'b0, 32'h831F_E000);
        check(fit_irq == 1'b0, "R8 masked", fit_irq, 0);
        check(stat_q[26] == 1'b1, "R8 flag held", stat_q[26], 1);
        wr(1'b0, 32'h8B9F_E000);
        check(fit_irq == 1'b1, "R8 unmasked", fit_irq, 1);
        wr(1'b1, 32'h0400_0000);
        check(fit_irq == 1'b0, "R8 cleared", fit_irq, 0);

        // R5 compact mode: period 2 taps bit 2, extension ignored
        wr(1'b0, 32'h0281_E000);
        tick(int'((8 - tb_nx[2:0]) % 8));
        idle(2);
        wr(1'b1, 32'hFFFF_FFFF);
        check(stat_nx[26] == 1'b0, "R5 cleared", stat_nx[26], 0);
        tick(3);
        idle(2);
        check(stat_nx[26] == 1'b0, "R5 low bits ignored", stat_nx[26], 0);
        tick(1);
        idle(2);
        check(stat_nx[26] == 1'b1, "R5 bit2 rise", stat_nx[26], 1);
        check(fit_irq_nx == 1'b1, "R5 irq", fit_irq_nx, 1);

        done = 1'b1;
        summary();
    end

endmodule